// File: doc/BRIEF.md
# Add-Only One-Time-Programmable Byte Memory

This block models a 1024-bit one-time-programmable store, organised as 128 bytes split into four 32-byte pages. A blank cell reads as FFh. Programming can only turn ones into zeros, so any write stores the bitwise AND of the byte already held and the byte offered. Existing data therefore survives any later write, and further bits can be added over several passes.

Page 0 holds a fixed factory record that is built at elaboration from two parameters: a 32-bit tag and a 64-bit node identifier. The record is a count byte, then the tag, then the node identifier, each least significant byte first. An inverted CRC-16 over those 13 bytes follows, and the rest of the page is FFh. Page 0 is locked for good. A small status register holds one protect flag per page. A user page (1 to 3) accepts programming until software locks it, and once a flag is set only reset clears it.

The read port is synchronous and has one cycle of latency. The program port gives a one-cycle pulse one cycle after each request: done when the write was accepted, error when the request hit a locked page.

Top module: `otp_addonly_mem`

## Requirements
- R1: The address is 7 bits and the page number is address bits [6:5]. After reset every byte of pages 1 to 3 reads FFh.
- R2: When rd_en is high at a rising clock edge, rd_data takes the byte at rd_addr on that edge. When rd_en is low, rd_data holds its value. Reset sets rd_data to FFh.
- R3: An accepted program of data D to an address whose byte is B leaves that byte equal to B AND D. No other address changes.
- R4: Page 0 reads as follows. Byte 00h holds 0Ch. Bytes 01h to 04h hold the tag, least significant byte first. Bytes 05h to 0Ch hold the node identifier, least significant byte first. Bytes 0Dh (low) and 0Eh (high) hold the bitwise inverse of a CRC-16 over bytes 00h to 0Ch. Bytes 0Fh to 1Fh hold FFh. The CRC uses the reflected polynomial x^16+x^15+x^2+1 (A001h), an initial value of 0, and takes each byte least significant bit first.
- R5: wp_flags bit 0 is always 1, and no program request changes any byte of page 0.
- R6: lock_en sets wp_flags[lock_page] on the next edge. Flags never clear except by reset, which loads 4'b0001. A lock request for page 0 changes nothing.
- R7: A program request to a page whose flag is set changes no byte and raises pg_err for exactly one cycle, one cycle after the request, with pg_done low.
- R8: A program request to an unlocked page raises pg_done for exactly one cycle, one cycle after the request, with pg_err low. With no request, both pulses stay low.
- R9: A read and a program of the same address in the same cycle return the old byte. A read in any later cycle returns the new byte.
- R10: The protect check uses the flags as they stand before the edge. A program and a lock of the same page in the same cycle is therefore accepted, and the page is locked afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; reloads the initial image |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 7 | Read byte address |
| rd_data | output | 8 | Registered read byte |
| pg_en | input | 1 | Program request strobe |
| pg_addr | input | 7 | Program byte address |
| pg_data | input | 8 | Program byte; zeros clear bits, ones leave them |
| pg_done | output | 1 | One-cycle pulse for an accepted program |
| pg_err | output | 1 | One-cycle pulse for a program refused by protection |
| lock_en | input | 1 | Request to set a page protect flag |
| lock_page | input | 2 | Page whose flag is set |
| wp_flags | output | 4 | Current protect flags, bit n for page n |

## Verification
The bench reads all 128 addresses and checks page 0 against a record and CRC that it computes bit by bit, so a wrong byte order, a CRC that is not inverted, or a wrong polynomial shows up as a page-0 miscompare. It programs every user address twice with patterns that overlap. A design that overwrites instead of ANDing, or that spills into a neighbouring byte, fails the read-back sweep. Page 0, a page locked at run time, and a lock request aimed at page 0 are each used to show that refused writes leave the bytes unchanged, give only an error pulse, and leave the flags as they were. The bench also drives a read and a program of the same address in one cycle, and a program and a lock of the same page in one cycle, so that getting either ordering wrong returns the new byte too early or refuses the write.

// File: rtl/otp_addonly_pkg.sv
package otp_addonly_pkg;

    localparam int OTP_BYTE_W     = 8;
    localparam int OTP_PAGES      = 4;
    localparam int OTP_PAGE_BYTES = 32;
    localparam int OTP_PAGE_W     = $clog2(OTP_PAGES);
    localparam int OTP_OFFS_W     = $clog2(OTP_PAGE_BYTES);
    localparam int OTP_ADDR_W     = OTP_PAGE_W + OTP_OFFS_W;

    localparam int REC_TAG_BYTES  = 4;
    localparam int REC_NODE_BYTES = 8;
    localparam int REC_BODY_BYTES = 1 + REC_TAG_BYTES + REC_NODE_BYTES;
    localparam int REC_CRC_LO     = REC_BODY_BYTES;
    localparam int REC_CRC_HI     = REC_BODY_BYTES + 1;

    localparam logic [OTP_BYTE_W-1:0] OTP_BLANK     = 8'hFF;
    localparam logic [15:0]           CRC_POLY_REFL = 16'hA001;
    localparam logic [OTP_PAGES-1:0]  WP_RESET_MASK = OTP_PAGES'(1);

    typedef logic [OTP_BYTE_W-1:0] otp_byte_t;

    typedef struct packed {
        logic [OTP_PAGE_W-1:0] page;
        logic [OTP_OFFS_W-1:0] offs;
    } otp_addr_t;

    typedef struct packed {
        logic      valid;
        otp_addr_t addr;
        otp_byte_t data;
    } otp_prog_t;

    typedef enum logic [1:0] {
        PROG_IDLE = 2'd0,
        PROG_DONE = 2'd1,
        PROG_DENY = 2'd2
    } otp_pres_t;

    // Byte idx of the record body: count, tag, node id (LSB first).
    function automatic otp_byte_t rec_body_byte(
        input logic [8*REC_TAG_BYTES-1:0]  tag,
        input logic [8*REC_NODE_BYTES-1:0] node,
        input int                          idx
    );
        otp_byte_t b;
        if (idx == 0)
            b = otp_byte_t'(REC_TAG_BYTES + REC_NODE_BYTES);
        else if (idx <= REC_TAG_BYTES)
            b = tag[8*(idx-1) +: 8];
        else
            b = node[8*(idx-1-REC_TAG_BYTES) +: 8];
        return b;
    endfunction

    function automatic logic [15:0] rec_crc(
        input logic [8*REC_TAG_BYTES-1:0]  tag,
        input logic [8*REC_NODE_BYTES-1:0] node
    );
        logic [15:0] c;
        c = 16'h0000;
        for (int i = 0; i < REC_BODY_BYTES; i++) begin
            c = c ^ {8'h00, rec_body_byte(tag, node, i)};
            for (int b = 0; b < 8; b++)
                c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
        end
        return c;
    endfunction

    function automatic otp_byte_t rec_image_byte(
        input logic [8*REC_TAG_BYTES-1:0]  tag,
        input logic [8*REC_NODE_BYTES-1:0] node,
        input logic [15:0]                 crc,
        input logic [OTP_OFFS_W-1:0]       offs
    );
        otp_byte_t b;
        if (int'(offs) < REC_BODY_BYTES)
            b = rec_body_byte(tag, node, int'(offs));
        else if (int'(offs) == REC_CRC_LO)
            b = ~crc[7:0];
        else if (int'(offs) == REC_CRC_HI)
            b = ~crc[15:8];
        else
            b = OTP_BLANK;
        return b;
    endfunction

endpackage

// File: rtl/otp_factory_rom.sv
module otp_factory_rom
    import otp_addonly_pkg::*;
#(
    parameter logic [8*REC_TAG_BYTES-1:0]  REC_TAG = 32'hA5C3_0019,
    parameter logic [8*REC_NODE_BYTES-1:0] NODE_ID = 64'h0012_3F80_9ABC_DE01
) (
    input  logic [OTP_OFFS_W-1:0] offs,
    output otp_byte_t             rd_byte
);
    localparam logic [15:0] REC_CRC = rec_crc(REC_TAG, NODE_ID);

    always_comb rd_byte = rec_image_byte(REC_TAG, NODE_ID, REC_CRC, offs);
endmodule

// File: rtl/otp_page_bank.sv
module otp_page_bank
    import otp_addonly_pkg::*;
#(
    parameter int BYTES = OTP_PAGE_BYTES,
    localparam int OW   = $clog2(BYTES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [OW-1:0] wr_offs,
    input  otp_byte_t     wr_data,
    input  logic [OW-1:0] rd_offs,
    output otp_byte_t     rd_byte
);
    otp_byte_t cells [BYTES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < BYTES; i++)
                cells[i] <= OTP_BLANK;
        end else if (wr_en) begin
            cells[wr_offs] <= cells[wr_offs] & wr_data;
        end
    end

    assign rd_byte = cells[rd_offs];
endmodule

// File: rtl/otp_wp_status.sv
module otp_wp_status
    import otp_addonly_pkg::*;
#(
    parameter int             PAGES     = OTP_PAGES,
    parameter logic [PAGES-1:0] INIT_MASK = WP_RESET_MASK,
    localparam int            PW        = $clog2(PAGES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lock_en,
    input  logic [PW-1:0]    lock_page,
    output logic [PAGES-1:0] flags
);
    always_ff @(posedge clk) begin
        if (rst)
            flags <= INIT_MASK;
        else if (lock_en)
            flags <= flags | (PAGES'(1) << lock_page);
    end
endmodule

// File: rtl/otp_prog_gate.sv
module otp_prog_gate
    import otp_addonly_pkg::*;
(
    input  otp_prog_t            req,
    input  logic [OTP_PAGES-1:0] flags,
    output logic [OTP_PAGES-1:1] bank_we,
    output otp_pres_t            res
);
    logic accept;

    always_comb begin
        accept = 1'b0;
        res    = PROG_IDLE;
        if (req.valid) begin
            if (flags[req.addr.page]) begin
                res = PROG_DENY;
            end else begin
                res    = PROG_DONE;
                accept = 1'b1;
            end
        end
    end

    always_comb begin
        for (int p = 1; p < OTP_PAGES; p++)
            bank_we[p] = accept && (int'(req.addr.page) == p);
    end
endmodule

// File: rtl/otp_addonly_mem.sv
module otp_addonly_mem
    import otp_addonly_pkg::*;
#(
    parameter logic [8*REC_TAG_BYTES-1:0]  REC_TAG = 32'hA5C3_0019,
    parameter logic [8*REC_NODE_BYTES-1:0] NODE_ID = 64'h0012_3F80_9ABC_DE01
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rd_en,
    input  logic [OTP_ADDR_W-1:0] rd_addr,
    output logic [OTP_BYTE_W-1:0] rd_data,
    input  logic                  pg_en,
    input  logic [OTP_ADDR_W-1:0] pg_addr,
    input  logic [OTP_BYTE_W-1:0] pg_data,
    output logic                  pg_done,
    output logic                  pg_err,
    input  logic                  lock_en,
    input  logic [OTP_PAGE_W-1:0] lock_page,
    output logic [OTP_PAGES-1:0]  wp_flags
);
    otp_prog_t            req;
    otp_addr_t            rd_a;
    otp_pres_t            res;
    logic [OTP_PAGES-1:1] bank_we;
    otp_byte_t            page_rd [OTP_PAGES];

    assign req.valid = pg_en;
    assign req.addr  = otp_addr_t'(pg_addr);
    assign req.data  = pg_data;
    assign rd_a      = otp_addr_t'(rd_addr);

    otp_wp_status u_wp (
        .clk       (clk),
        .rst       (rst),
        .lock_en   (lock_en),
        .lock_page (lock_page),
        .flags     (wp_flags)
    );

    otp_prog_gate u_gate (
        .req     (req),
        .flags   (wp_flags),
        .bank_we (bank_we),
        .res     (res)
    );

    otp_factory_rom #(
        .REC_TAG (REC_TAG),
        .NODE_ID (NODE_ID)
    ) u_rom (
        .offs    (rd_a.offs),
        .rd_byte (page_rd[0])
    );

    for (genvar g = 1; g < OTP_PAGES; g++) begin : g_bank
        otp_page_bank #(.BYTES(OTP_PAGE_BYTES)) u_bank (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (bank_we[g]),
            .wr_offs (req.addr.offs),
            .wr_data (req.data),
            .rd_offs (rd_a.offs),
            .rd_byte (page_rd[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pg_done <= 1'b0;
            pg_err  <= 1'b0;
        end else begin
            pg_done <= (res == PROG_DONE);
            pg_err  <= (res == PROG_DENY);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_data <= OTP_BLANK;
        else if (rd_en)
            rd_data <= page_rd[rd_a.page];
    end
endmodule

// File: rtl/otp_addonly_chk.sv
module otp_addonly_chk
    import otp_addonly_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  rd_en,
    input logic [OTP_BYTE_W-1:0] rd_data,
    input logic                  pg_en,
    input logic [OTP_ADDR_W-1:0] pg_addr,
    input logic                  pg_done,
    input logic                  pg_err,
    input logic                  lock_en,
    input logic [OTP_PAGE_W-1:0] lock_page,
    input logic [OTP_PAGES-1:0]  wp_flags
);
    logic [OTP_PAGE_W-1:0] pg_page;
    assign pg_page = pg_addr[OTP_ADDR_W-1 -: OTP_PAGE_W];

    AST_PAGE0_LOCKED: assert property (@(posedge clk) disable iff (rst)
        wp_flags[0]); // R5

    AST_WP_STICKY: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((wp_flags & $past(wp_flags)) == $past(wp_flags))); // R6

    AST_LOCK_SETS: assert property (@(posedge clk) disable iff (rst)
        lock_en |=> wp_flags[$past(lock_page)]); // R6

    AST_DENY_PULSE: assert property (@(posedge clk) disable iff (rst)
        (pg_en && wp_flags[pg_page]) |=> (pg_err && !pg_done)); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        (pg_en && !wp_flags[pg_page]) |=> (pg_done && !pg_err)); // R8

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !pg_en |=> (!pg_done && !pg_err)); // R8

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rd_en)) |-> $stable(rd_data)); // R2
endmodule

bind otp_addonly_mem otp_addonly_chk u_chk (.*);

// File: tb/otp_addonly_mem_bench.sv
`timescale 1ns/1ps
module otp_addonly_mem_bench;
    localparam logic [31:0] TAG  = 32'hA5C3_0019;
    localparam logic [63:0] NODE = 64'h0012_3F80_9ABC_DE01;

    logic       clk = 1'b0;
    logic       rst, rd_en, pg_en, lock_en;
    logic [6:0] rd_addr, pg_addr;
    logic [7:0] pg_data, rd_data;
    logic [1:0] lock_page;
    logic       pg_done, pg_err;
    logic [3:0] wp_flags;

    int         n_vec = 0;
    int         n_bad = 0;
    logic [7:0] model [128];
    logic [3:0] wp_m;

    always #2 clk = ~clk;

    otp_addonly_mem #(.REC_TAG(TAG), .NODE_ID(NODE)) u_otp_addonly_mem (
        .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .pg_en(pg_en), .pg_addr(pg_addr), .pg_data(pg_data),
        .pg_done(pg_done), .pg_err(pg_err),
        .lock_en(lock_en), .lock_page(lock_page), .wp_flags(wp_flags)
    );

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // Factory record computed from the requirement text, bit-serial CRC.
    task automatic build_image();
        logic [7:0]  body [13];
        logic [15:0] c;
        logic        fb;
        body[0] = 8'h0C;
        for (int k = 0; k < 4; k++) body[1+k] = TAG[8*k +: 8];
        for (int k = 0; k < 8; k++) body[5+k] = NODE[8*k +: 8];
        c = 16'h0;
        for (int i = 0; i < 13; i++)
            for (int b = 0; b < 8; b++) begin
                fb = c[0] ^ body[i][b];
                c  = c >> 1;
                if (fb) c = c ^ 16'hA001;
            end
        for (int a = 0; a < 128; a++) model[a] = 8'hFF;
        for (int i = 0; i < 13; i++) model[i] = body[i];
        model[13] = ~c[7:0];
        model[14] = ~c[15:8];
        wp_m = 4'b0001;
    endtask

    task automatic do_read(input int a, input string what);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = 7'(a);
        @(negedge clk);
        rd_en = 1'b0;
        check($sformatf("%s addr %0h", what, a), {24'h0, rd_data}, {24'h0, model[a]});
    endtask

    task automatic do_prog(input int a, input logic [7:0] d, input string what);
        logic locked;
        locked = wp_m[a >> 5];
        @(negedge clk);
        pg_en = 1'b1; pg_addr = 7'(a); pg_data = d;
        @(negedge clk);
        pg_en = 1'b0;
        if (locked) begin
            check({what, " R7 err"},  {31'h0, pg_err},  32'h1);
            check({what, " R7 done"}, {31'h0, pg_done}, 32'h0);
        end else begin
            check({what, " R8 done"}, {31'h0, pg_done}, 32'h1);
            check({what, " R8 err"},  {31'h0, pg_err},  32'h0);
            model[a] = model[a] & d;
        end
    endtask

    task automatic do_lock(input int p);
        @(negedge clk);
        lock_en = 1'b1; lock_page = 2'(p);
        @(negedge clk);
        lock_en = 1'b0;
        wp_m[p] = 1'b1;
        check("R6 flags after lock", {28'h0, wp_flags}, {28'h0, wp_m});
    endtask

    task automatic sweep_read(input string what);
        for (int a = 0; a < 128; a++) do_read(a, what);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] held;
        rst = 1'b1; rd_en = 1'b0; pg_en = 1'b0; lock_en = 1'b0;
        rd_addr = '0; pg_addr = '0; pg_data = '0; lock_page = '0;
        build_image();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // Reset state
        check("R6 reset flags", {28'h0, wp_flags}, 32'h1);
        check("R2 reset rd_data", {24'h0, rd_data}, 32'hFF);
        check("R8 reset done", {31'h0, pg_done}, 32'h0);
        check("R7 reset err",  {31'h0, pg_err},  32'h0);

        // R4 page 0 image and R1 blank user pages
        sweep_read("R4/R1 initial");

        // R5: every page-0 byte refused
        for (int a = 0; a < 32; a++) do_prog(a, 8'h00, "R5 page0");
        for (int a = 0; a < 32; a++) do_read(a, "R5 page0 unchanged");

        // R3: two overlapping passes over all user bytes
        for (int a = 32; a < 128; a++) do_prog(a, 8'((a * 73 + 29) | 8'h81), "R3 pass1");
        sweep_read("R3 after pass1");
        for (int a = 32; a < 128; a++) do_prog(a, ~8'(a * 5), "R3 pass2");
        sweep_read("R3 after pass2");

        // R6/R7: lock page 2, then try every byte of it
        do_lock(2);
        for (int a = 64; a < 96; a++) do_prog(a, 8'h00, "R7 page2");
        for (int a = 64; a < 96; a++) do_read(a, "R7 page2 unchanged");
        do_prog(33, 8'h7E, "R8 page1 still open");
        do_read(33, "R3 page1 after lock2");

        // R6: lock request for page 0 changes nothing
        do_lock(0);
        check("R6 page0 lock no change", {28'h0, wp_flags}, 32'h5);

        // R9: read and program of the same address in one cycle
        held = model[100];
        @(negedge clk);
        rd_en = 1'b1; rd_addr = 7'd100;
        pg_en = 1'b1; pg_addr = 7'd100; pg_data = 8'h0F;
        @(negedge clk);
        rd_en = 1'b0; pg_en = 1'b0;
        check("R9 same-cycle read old", {24'h0, rd_data}, {24'h0, held});
        check("R9 same-cycle done", {31'h0, pg_done}, 32'h1);
        model[100] = held & 8'h0F;
        do_read(100, "R9 later read new");

        // R2: rd_data holds while rd_en is low
        held = rd_data;
        @(negedge clk);
        rd_addr = 7'd0;
        repeat (2) @(negedge clk);
        check("R2 hold with rd_en low", {24'h0, rd_data}, {24'h0, held});

        // R10: program and lock of page 3 in the same cycle
        @(negedge clk);
        pg_en = 1'b1; pg_addr = 7'h70; pg_data = 8'h3C;
        lock_en = 1'b1; lock_page = 2'd3;
        @(negedge clk);
        pg_en = 1'b0; lock_en = 1'b0;
        check("R10 same-cycle program accepted", {31'h0, pg_done}, 32'h1);
        check("R10 same-cycle err", {31'h0, pg_err}, 32'h0);
        model[7'h70] = model[7'h70] & 8'h3C;
        wp_m[3] = 1'b1;
        check("R10 page3 locked", {28'h0, wp_flags}, 32'hD);
        do_prog(7'h71, 8'h00, "R10 page3 refused");
        do_read(7'h70, "R10 byte written");
        do_read(7'h71, "R10 byte untouched");

        // R1/R6: reset reloads the initial image
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        build_image();
        check("R6 flags after reset", {28'h0, wp_flags}, 32'h1);
        sweep_read("R1/R4 after reset");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule